// File: doc/BRIEF.md
# SPI Slave Packet Framer

This block is the receive side of an SPI slave link whose traffic is cut into packets of a fixed length. It works in SPI mode 0: MOSI is sampled on each rising SCLK edge, most significant bit first. The active-low chip select marks out frames. A single frame may carry any number of packets sent one after another. Each packet is a fixed number of payload bytes followed by one CRC byte. SCLK, MOSI and chip select are resynchronised into the system clock domain, and SCLK edges are found there. For this reason the system clock must run at four or more times the SCLK rate.

Any change of chip select puts the bit and byte counters back to zero. A lost or extra byte therefore cannot shift the packets that follow it, beyond the end of the current frame. A packet that arrives whole and has a correct CRC goes out on a valid/ready stream as one wide word. A frame that ends partway through a packet, a CRC mismatch, or a packet that finds the output still occupied each raises a one-cycle error pulse, and that packet is dropped. A saturating counter totals these error events.

Top module: `spi_frame_rx`

## Requirements
- R1: After reset, `outValid` and the three error pulses are low and `errCount` is zero.
- R2: Payload bits are taken on rising SCLK edges while chip select is low, MSB first. The first payload byte received appears in `outData[W-1:W-8]`, and later bytes fill lower bit positions in order.
- R3: A single chip-select frame may carry several back-to-back packets. Each packet starts on the byte that follows the previous packet's CRC byte, and every valid packet is presented on the output.
- R4: Bit and byte counts restart at every chip-select edge. If chip select rises after 1 to 8*(PAYLOAD_BYTES+1)-1 bits of a packet, that partial packet is dropped and `errShort` pulses once. A frame that ends exactly on a packet boundary raises no error. The first packet of the next frame is aligned correctly.
- R5: If the CRC byte does not match, the packet is dropped, `errCrc` pulses once, and all further bits of that frame are ignored. Reception starts again at the next chip-select assertion.
- R6: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` does not change. A cycle in which both are high takes the word, and `outValid` then falls unless a new packet completes in that same cycle.
- R7: If a packet completes with a correct CRC while an earlier word is still waiting to be taken, the new packet is dropped, `errOverrun` pulses once, and the waiting word is kept.
- R8: Each error pulse adds one to `errCount`. The count saturates at 255. At most one error pulse is high in any cycle.
- R9: While `errClear` is high, `errCount` is cleared to zero on the next clock edge. The clear takes priority over an increment in the same cycle.
- R10: The CRC is CRC-8 with polynomial 0x07 and initial value 0x00. It is computed MSB first over the payload bytes and sent as the byte that follows them. A flip of any single bit of the CRC byte is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCLK rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low (mode 0) |
| mosi | input | 1 | SPI data in |
| csN | input | 1 | Active-low chip select that bounds frames |
| outReady | input | 1 | Sink ready for the packet word |
| errClear | input | 1 | Synchronous clear of the error counter |
| outValid | output | 1 | Packet word available |
| outData | output | 8*PAYLOAD_BYTES | Payload, first byte in the top bits |
| errShort | output | 1 | Pulse: frame ended inside a packet |
| errCrc | output | 1 | Pulse: CRC mismatch |
| errOverrun | output | 1 | Pulse: valid packet dropped because the output was occupied |
| errCount | output | 8 | Saturating error event count |

## Verification
The bench runs a small two-byte-payload configuration. Frames carrying one, two and three back-to-back packets check byte ordering and the packet boundaries within a frame. A sweep cuts a frame off after every possible bit count inside a packet; each cut must give exactly one short error, and the frame that follows must still align correctly. Every single-bit corruption of the CRC byte is sent, each followed by a good packet in the same frame, to show both that the check covers every bit and that the rest of the frame is ignored. Two packets sent to a stalled sink confirm the overrun and hold behaviour. Several hundred short frames push the error counter to its saturation limit.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  // Strobes from the control path to the datapath, one cycle each.
  typedef struct packed {
    logic shiftEn;   // take one MOSI bit this cycle
    logic crcPhase;  // the bit belongs to the CRC byte
    logic pktDone;   // last bit of the CRC byte
    logic shortErr;  // frame closed inside a packet
    logic clearPkt;  // chip-select edge: drop partial state
  } frameStrobe_t;
endpackage

// File: rtl/spi_frame_sync.sv
module spi_frame_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RESET_VAL[i];
        stage2 <= RESET_VAL[i];
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkS,
  input  logic         csS,
  input  logic         crcFail,
  output frameStrobe_t strobe
);
  localparam int TOTAL_BYTES = PAYLOAD_BYTES + 1;
  localparam int BYTE_W = (TOTAL_BYTES > 1) ? $clog2(TOTAL_BYTES) : 1;
  localparam logic [BYTE_W-1:0] CRC_IDX = BYTE_W'(PAYLOAD_BYTES);

  logic              sclkPrev;
  logic              csPrev;
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] byteCnt;
  logic              hunt;     // frame abandoned after a CRC failure
  logic              csEdge;
  logic              sclkRise;

  assign csEdge   = csS != csPrev;
  assign sclkRise = sclkS && !sclkPrev;

  always_comb begin
    strobe = '0;
    if (csEdge) begin
      strobe.clearPkt = 1'b1;
      strobe.shortErr = csS && ((bitCnt != 3'd0) || (byteCnt != '0));
    end else if (sclkRise && !csS && !hunt) begin
      strobe.shiftEn  = 1'b1;
      strobe.crcPhase = (byteCnt == CRC_IDX);
      strobe.pktDone  = (byteCnt == CRC_IDX) && (bitCnt == 3'd7);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
      bitCnt   <= '0;
      byteCnt  <= '0;
      hunt     <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
      if (csEdge) begin
        bitCnt  <= '0;
        byteCnt <= '0;
        hunt    <= 1'b0;
      end else begin
        if (crcFail) hunt <= 1'b1;
        if (strobe.shiftEn) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7)
            byteCnt <= strobe.crcPhase ? '0 : byteCnt + BYTE_W'(1);
        end
      end
    end
  end

  p_align_on_cs_r4: assert property (@(posedge clk) disable iff (!rstN)
    csEdge |=> (bitCnt == 3'd0 && byteCnt == '0));

  p_hunt_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    hunt |-> !strobe.shiftEn);

  p_byte_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CRC_IDX);
endmodule

// File: rtl/spi_frame_dp.sv
module spi_frame_dp
  import spi_frame_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  frameStrobe_t               strobe,
  input  logic                       bitIn,
  input  logic                       outReady,
  input  logic                       errClear,
  output logic                       crcFail,
  output logic                       outValid,
  output logic [PAYLOAD_BYTES*8-1:0] outData,
  output logic                       errShort,
  output logic                       errCrc,
  output logic                       errOverrun,
  output logic [7:0]                 errCount
);
  localparam int DATA_W = PAYLOAD_BYTES * 8;
  localparam logic [7:0] POLY = 8'h07;

  logic [DATA_W-1:0] payloadSr;
  logic [7:0]        crcAcc;
  logic [7:0]        crcRx;
  logic [7:0]        crcRxNext;
  logic              pktGood;
  logic              overrun;

  assign crcRxNext = {crcRx[6:0], bitIn};
  assign crcFail   = strobe.pktDone && (crcRxNext != crcAcc);
  assign pktGood   = strobe.pktDone && !crcFail;
  assign overrun   = pktGood && outValid && !outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      payloadSr <= '0;
      crcAcc    <= '0;
      crcRx     <= '0;
    end else begin
      if (strobe.clearPkt || strobe.pktDone)
        crcAcc <= '0;
      else if (strobe.shiftEn && !strobe.crcPhase)
        crcAcc <= {crcAcc[6:0], 1'b0} ^ ((crcAcc[7] ^ bitIn) ? POLY : 8'h00);
      if (strobe.shiftEn) begin
        if (strobe.crcPhase) crcRx <= crcRxNext;
        else                 payloadSr <= {payloadSr[DATA_W-2:0], bitIn};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (outValid && outReady) outValid <= 1'b0;
      if (pktGood && !overrun) begin
        outValid <= 1'b1;
        outData  <= payloadSr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errShort   <= 1'b0;
      errCrc     <= 1'b0;
      errOverrun <= 1'b0;
      errCount   <= '0;
    end else begin
      errShort   <= strobe.shortErr;
      errCrc     <= crcFail;
      errOverrun <= overrun;
      if (errClear)
        errCount <= '0;
      else if ((errShort || errCrc || errOverrun) && errCount != 8'hFF)
        errCount <= errCount + 8'd1;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  p_bad_crc_no_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    (crcFail && !outValid) |=> !outValid);

  p_one_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errShort, errCrc, errOverrun}));

  p_sat_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == 8'hFF && !errClear) |=> errCount == 8'hFF);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    errClear |=> errCount == 8'h00);
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_frame_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclk,
  input  logic                       mosi,
  input  logic                       csN,
  input  logic                       outReady,
  input  logic                       errClear,
  output logic                       outValid,
  output logic [PAYLOAD_BYTES*8-1:0] outData,
  output logic                       errShort,
  output logic                       errCrc,
  output logic                       errOverrun,
  output logic [7:0]                 errCount
);
  logic [2:0]   pinsSync;
  frameStrobe_t strobe;
  logic         crcFail;

  spi_frame_sync #(.WIDTH(3), .RESET_VAL(3'b001)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({sclk, mosi, csN}),
    .syncOut(pinsSync)
  );

  spi_frame_ctrl #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .sclkS(pinsSync[2]), .csS(pinsSync[0]),
    .crcFail(crcFail), .strobe(strobe)
  );

  spi_frame_dp #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) dp_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .bitIn(pinsSync[1]),
    .outReady(outReady), .errClear(errClear),
    .crcFail(crcFail),
    .outValid(outValid), .outData(outData),
    .errShort(errShort), .errCrc(errCrc), .errOverrun(errOverrun),
    .errCount(errCount)
  );
endmodule

// File: tb/spi_frame_rx_tb_top.sv
module spi_frame_rx_tb_top;
  localparam int P = 2;
  localparam int W = P * 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, sclk = 1'b0, mosi = 1'b0, csN = 1'b1;
  logic outReady = 1'b0, errClear = 1'b0;
  logic outValid, errShort, errCrc, errOverrun;
  logic [W-1:0] outData;
  logic [7:0] errCount;

  spi_frame_rx #(.PAYLOAD_BYTES(P)) dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .mosi(mosi), .csN(csN),
    .outReady(outReady), .errClear(errClear),
    .outValid(outValid), .outData(outData),
    .errShort(errShort), .errCrc(errCrc), .errOverrun(errOverrun),
    .errCount(errCount)
  );

  int total = 0, bad = 0;
  int nShort = 0, nCrc = 0, nOvr = 0, accN = 0;
  logic [W-1:0] acc [0:63];

  always @(negedge clk) begin
    if (errShort) nShort++;
    if (errCrc) nCrc++;
    if (errOverrun) nOvr++;
    if (outValid && outReady) begin
      if (accN < 64) acc[accN] = outData;
      accN++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [W-1:0] d);
    logic [7:0] c = 8'h00;
    for (int i = W - 1; i >= 0; i--)
      c = {c[6:0], 1'b0} ^ ((c[7] ^ d[i]) ? 8'h07 : 8'h00);
    return c;
  endfunction

  function automatic logic [W-1:0] pat(input int k);
    return W'(32'hA5C3 ^ (k * 32'h1357));
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk) mosi = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sendPkt(input logic [W-1:0] d, input logic [7:0] flip);
    logic [W+7:0] s;
    s = {d, crc8(d) ^ flip};
    for (int i = W + 7; i >= 0; i--) sendBit(s[i]);
  endtask

  task automatic csOn();
    @(negedge clk) csN = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic csOff();
    repeat (8) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base, sh, cr, ov, expErr;
    logic [W+7:0] s;
    expErr = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outValid", 32'(outValid), 0);
    chk("R1 errors", 32'({errShort, errCrc, errOverrun}), 0);
    chk("R1 errCount", 32'(errCount), 0);

    outReady = 1'b1;
    // R2 R3 R10: frames of 1..3 packets
    for (int n = 1; n <= 3; n++) begin
      base = accN; sh = nShort;
      csOn();
      for (int k = 0; k < n; k++) sendPkt(pat(n * 4 + k), 8'h00);
      csOff();
      chk("R3 packet count", 32'(accN - base), 32'(n));
      for (int k = 0; k < n; k++) chk("R2 payload order", 32'(acc[base + k]), 32'(pat(n * 4 + k)));
      chk("R4 no error on boundary", 32'(nShort - sh), 0);
    end

    // R4: cut off after every bit count inside a packet, then realign
    for (int b = 1; b < (P + 1) * 8; b++) begin
      base = accN; sh = nShort;
      s = {pat(100 + b), crc8(pat(100 + b))};
      csOn();
      for (int i = 0; i < b; i++) sendBit(s[W + 7 - i]);
      csOff();
      expErr++;
      chk("R4 short pulse", 32'(nShort - sh), 1);
      chk("R4 partial dropped", 32'(accN - base), 0);
      csOn();
      sendPkt(pat(200 + b), 8'h00);
      csOff();
      chk("R4 realigned count", 32'(accN - base), 1);
      chk("R4 realigned data", 32'(acc[base]), 32'(pat(200 + b)));
    end

    // R4: good packet then partial in one frame
    base = accN; sh = nShort;
    csOn();
    sendPkt(pat(40), 8'h00);
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    csOff();
    expErr++;
    chk("R4 good before partial", 32'(accN - base), 1);
    chk("R4 short after good", 32'(nShort - sh), 1);

    // R5 R10: each single-bit CRC corruption; rest of frame ignored
    for (int j = 0; j < 8; j++) begin
      base = accN; cr = nCrc;
      csOn();
      sendPkt(pat(50 + j), 8'(1 << j));
      sendPkt(pat(60 + j), 8'h00);
      csOff();
      expErr++;
      chk("R10 crc flip detected", 32'(nCrc - cr), 1);
      chk("R5 frame ignored", 32'(accN - base), 0);
      csOn();
      sendPkt(pat(70 + j), 8'h00);
      csOff();
      chk("R5 resync data", 32'(acc[base]), 32'(pat(70 + j)));
    end

    // R6 R7: stalled sink
    outReady = 1'b0;
    ov = nOvr; base = accN;
    csOn();
    sendPkt(pat(80), 8'h00);
    sendPkt(pat(81), 8'h00);
    csOff();
    expErr++;
    chk("R7 overrun pulse", 32'(nOvr - ov), 1);
    chk("R7 kept valid", 32'(outValid), 1);
    chk("R7 kept first word", 32'(outData), 32'(pat(80)));
    repeat (20) @(negedge clk);
    chk("R6 hold valid", 32'(outValid), 1);
    chk("R6 hold data", 32'(outData), 32'(pat(80)));
    outReady = 1'b1;
    @(negedge clk);
    chk("R6 accepted", 32'(outValid), 0);
    chk("R6 accepted word", 32'(acc[base]), 32'(pat(80)));

    // R8 count, R9 clear
    chk("R8 errCount", 32'(errCount), 32'(expErr));
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    chk("R9 cleared", 32'(errCount), 0);
    for (int i = 0; i < 260; i++) begin
      csOn();
      sendBit(1'b1);
      csOff();
    end
    chk("R8 saturated", 32'(errCount), 255);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    chk("R9 cleared from max", 32'(errCount), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule